// File: doc/BRIEF.md
# Conditional Skip and Panel-Load Unit

This combinational unit decodes one operate word of the skip-and-panel class for a twelve-bit accumulator machine. It decides whether the instruction after it is skipped and forms the new accumulator value. The skip decision is made from three tests on the accumulator and link: sign, zero and link. A sense bit chooses between two modes. In one mode the unit skips when any enabled test is true. In the other mode each test is inverted and the unit skips only when all enabled inverted tests are true.

After the skip decision, the unit applies three steps in a fixed order. It can clear the accumulator, then OR a twelve-bit switch-register input into it, then raise a halt request. The unit also reports whether the presented word belongs to its class. A sequencer that owns the program counter uses the skip flag, the new accumulator and the halt level in the same cycle that the word is presented. Words outside the class leave every output neutral.

Top module: `skip_unit`

## Requirements
- R1: `grp_hit` is 1 exactly when op_word[11:9] = 3'b111, op_word[8] = 1 and op_word[0] = 0. A word with op_word[0] = 1 belongs to the arithmetic-extension class and gives `grp_hit` = 0.
- R2: When `grp_hit` is 0, `skip` and `halt_req` are 0 and `acc_out` equals `acc_in`, whatever the other bits of the word are.
- R3: With the sense bit op_word[3] = 0, the unit skips if any enabled test holds. op_word[6] enables "AC negative" (acc_in[11] = 1), op_word[5] enables "AC zero", and op_word[4] enables "link = 1".
- R4: With op_word[3] = 1, the same three enables select "AC non-negative", "AC nonzero" and "link = 0". The unit skips only if every enabled inverted test holds.
- R5: With no test enabled, the unit always skips when op_word[3] = 1 (octal 7410) and never skips when op_word[3] = 0 (octal 7400).
- R6: The skip tests look at `acc_in` before any clear. For example, octal 7640 with acc_in = 0 skips and also clears the accumulator.
- R7: op_word[7] set clears the accumulator before the switch OR.
- R8: op_word[2] set ORs `switches` into the accumulator after the clear. Octal 7604 loads `acc_out` with `switches`.
- R9: `halt_req` is 1 in the cycle a class word with op_word[10]... with op_word[1] = 1 is presented, and 0 otherwise.
- R10: `link_out` always equals `link_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_word | input | 12 | Instruction word (index 11 = most significant) |
| acc_in | input | 12 | Accumulator before the instruction |
| link_in | input | 1 | Link before the instruction |
| switches | input | 12 | Switch-register value |
| grp_hit | output | 1 | Word belongs to this class |
| skip | output | 1 | Skip the next instruction |
| acc_out | output | 12 | Accumulator after the instruction |
| link_out | output | 1 | Link after the instruction |
| halt_req | output | 1 | Halt request level |

## Verification
The unit holds no state, so a fault in decode or ordering shows up at the ports in the same cycle the word is applied. A wrong sense inversion shows as a wrong skip on one of the six named tests. The boundary accumulator values 0000, 3777, 4000 and 7777 separate the sign test from the zero test. A clear applied before the tests shows as a skip mismatch on combined words such as 7640. A decode fault shows as outputs that fail to stay neutral for words with op_word[0] set.

// File: rtl/skip_unit.sv
module skip_unit #(
  parameter int DATA_W = 12
) (
  input  logic [11:0]       op_word,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              link_in,
  input  logic [DATA_W-1:0] switches,
  output logic              grp_hit,
  output logic              skip,
  output logic [DATA_W-1:0] acc_out,
  output logic              link_out,
  output logic              halt_req
);
  localparam int B_GRP = 8;
  localparam int B_CLR = 7;
  localparam int B_NEG = 6;
  localparam int B_ZER = 5;
  localparam int B_LNK = 4;
  localparam int B_SNS = 3;
  localparam int B_SWR = 2;
  localparam int B_HLT = 1;
  localparam int B_EXT = 0;

  logic ac_neg, ac_zero, any_hit, all_hit;
  logic [DATA_W-1:0] after_clr, after_swr;

  assign grp_hit = (op_word[11:9] == 3'b111) && op_word[B_GRP] && !op_word[B_EXT];

  assign ac_neg  = acc_in[DATA_W-1];
  assign ac_zero = (acc_in == '0);

  assign any_hit = (op_word[B_NEG] & ac_neg) | (op_word[B_ZER] & ac_zero)
                 | (op_word[B_LNK] & link_in);
  assign all_hit = (~op_word[B_NEG] | ~ac_neg) & (~op_word[B_ZER] | ~ac_zero)
                 & (~op_word[B_LNK] | ~link_in);

  assign skip = grp_hit & (op_word[B_SNS] ? all_hit : any_hit);

  assign after_clr = op_word[B_CLR] ? '0 : acc_in;
  assign after_swr = op_word[B_SWR] ? (after_clr | switches) : after_clr;

  assign acc_out  = grp_hit ? after_swr : acc_in;
  assign halt_req = grp_hit & op_word[B_HLT];
  assign link_out = link_in;
endmodule

// File: rtl/skip_unit_chk.sv
module skip_unit_chk #(
  parameter int DATA_W = 12
) (
  input logic [11:0]       op_word,
  input logic [DATA_W-1:0] acc_in,
  input logic              link_in,
  input logic [DATA_W-1:0] switches,
  input logic              grp_hit,
  input logic              skip,
  input logic [DATA_W-1:0] acc_out,
  input logic              link_out,
  input logic              halt_req
);
  always_comb begin
    if (op_word[0])
      p_ext_reject_r1: assert (!grp_hit);
    if (!grp_hit)
      p_neutral_r2: assert (!skip && !halt_req && acc_out == acc_in);
    if (grp_hit && !op_word[3] && op_word[6] && acc_in[DATA_W-1])
      p_or_neg_r3: assert (skip);
    if (grp_hit && op_word[3] && op_word[5] && acc_in == '0)
      p_and_nonzero_r4: assert (!skip);
    if (grp_hit && op_word[6:3] == 4'b0001)
      p_always_r5: assert (skip);
    if (grp_hit && op_word[6:3] == 4'b0000)
      p_never_r5: assert (!skip);
    if (grp_hit && !op_word[3] && op_word[5] && op_word[7] && acc_in == '0)
      p_pre_clear_r6: assert (skip);
    if (grp_hit && op_word[7] && !op_word[2])
      p_clear_r7: assert (acc_out == '0);
    if (grp_hit && op_word[2])
      p_swr_or_r8: assert ((acc_out & switches) == switches);
    if (halt_req)
      p_halt_r9: assert (grp_hit && op_word[1]);
    p_link_r10: assert (link_out == link_in);
  end
endmodule

bind skip_unit skip_unit_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_skip_unit.sv
module test_skip_unit;
  logic        clk = 1'b0;
  logic [11:0] op_word = 12'o0000;
  logic [11:0] acc_in = '0;
  logic        link_in = 1'b0;
  logic [11:0] switches = '0;
  logic        grp_hit, skip, link_out, halt_req;
  logic [11:0] acc_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  skip_unit i_skip_unit (
    .op_word(op_word), .acc_in(acc_in), .link_in(link_in), .switches(switches),
    .grp_hit(grp_hit), .skip(skip), .acc_out(acc_out), .link_out(link_out),
    .halt_req(halt_req)
  );

  // op, ac, link, sw, exp_skip, exp_ac, exp_halt, exp_grp
  localparam int NV = 23;
  localparam logic [51:0] VEC [0:NV-1] = '{
    {12'o7400, 12'o1234, 1'b0, 12'o0000, 1'b0, 12'o1234, 1'b0, 1'b1},
    {12'o7410, 12'o1234, 1'b0, 12'o0000, 1'b1, 12'o1234, 1'b0, 1'b1},
    {12'o7600, 12'o5555, 1'b1, 12'o7777, 1'b0, 12'o0000, 1'b0, 1'b1},
    {12'o7604, 12'o1111, 1'b0, 12'o2345, 1'b0, 12'o2345, 1'b0, 1'b1},
    {12'o7404, 12'o1010, 1'b0, 12'o0101, 1'b0, 12'o1111, 1'b0, 1'b1},
    {12'o7402, 12'o0077, 1'b0, 12'o0000, 1'b0, 12'o0077, 1'b1, 1'b1},
    {12'o7640, 12'o0000, 1'b0, 12'o0000, 1'b1, 12'o0000, 1'b0, 1'b1},
    {12'o7640, 12'o0001, 1'b0, 12'o0000, 1'b0, 12'o0000, 1'b0, 1'b1},
    {12'o7650, 12'o0001, 1'b0, 12'o0000, 1'b1, 12'o0000, 1'b0, 1'b1},
    {12'o7643, 12'o4321, 1'b0, 12'o7777, 1'b0, 12'o4321, 1'b0, 1'b0},
    {12'o7000, 12'o4321, 1'b1, 12'o7777, 1'b0, 12'o4321, 1'b0, 1'b0},
    {12'o1234, 12'o0000, 1'b1, 12'o7777, 1'b0, 12'o0000, 1'b0, 1'b0},
    {12'o7540, 12'o4000, 1'b0, 12'o0000, 1'b1, 12'o4000, 1'b0, 1'b1},
    {12'o7540, 12'o0000, 1'b0, 12'o0000, 1'b1, 12'o0000, 1'b0, 1'b1},
    {12'o7540, 12'o0001, 1'b0, 12'o0000, 1'b0, 12'o0001, 1'b0, 1'b1},
    {12'o7550, 12'o0001, 1'b0, 12'o0000, 1'b1, 12'o0001, 1'b0, 1'b1},
    {12'o7550, 12'o0000, 1'b0, 12'o0000, 1'b0, 12'o0000, 1'b0, 1'b1},
    {12'o7550, 12'o4000, 1'b0, 12'o0000, 1'b0, 12'o4000, 1'b0, 1'b1},
    {12'o7560, 12'o0001, 1'b1, 12'o0000, 1'b1, 12'o0001, 1'b0, 1'b1},
    {12'o7530, 12'o3777, 1'b0, 12'o0000, 1'b1, 12'o3777, 1'b0, 1'b1},
    {12'o7530, 12'o3777, 1'b1, 12'o0000, 1'b0, 12'o3777, 1'b0, 1'b1},
    {12'o7606, 12'o7777, 1'b0, 12'o0000, 1'b0, 12'o0000, 1'b1, 1'b1},
    {12'o7710, 12'o4000, 1'b0, 12'o0000, 1'b0, 12'o0000, 1'b0, 1'b1}
  };

  task automatic check(input string req, input string what, input logic [11:0] act,
                       input logic [11:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %o expected %o", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [11:0] op, input logic [11:0] ac, input logic l,
                       input logic [11:0] sw);
    @(posedge clk);
    op_word = op; acc_in = ac; link_in = l; switches = sw;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] skop [0:5];
    logic [11:0] acv [0:3];
    skop = '{12'o7500, 12'o7440, 12'o7420, 12'o7510, 12'o7450, 12'o7430};
    acv  = '{12'o0000, 12'o3777, 12'o4000, 12'o7777};

    // idle state: word 0000 is outside the class (R1, R2)
    @(negedge clk);
    check("R1", "idle grp_hit", {11'd0, grp_hit}, 12'd0);
    check("R2", "idle skip", {11'd0, skip}, 12'd0);
    check("R9", "idle halt", {11'd0, halt_req}, 12'd0);

    // vector table covering R1..R10
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][51:40], VEC[i][39:28], VEC[i][27], VEC[i][26:15]);
      check("R1", $sformatf("vec%0d grp_hit", i), {11'd0, grp_hit}, {11'd0, VEC[i][0]});
      check("R3/R4/R5/R6", $sformatf("vec%0d skip", i), {11'd0, skip}, {11'd0, VEC[i][14]});
      check("R2/R7/R8", $sformatf("vec%0d acc_out", i), acc_out, VEC[i][13:2]);
      check("R9", $sformatf("vec%0d halt", i), {11'd0, halt_req}, {11'd0, VEC[i][1]});
      check("R10", $sformatf("vec%0d link", i), {11'd0, link_out}, {11'd0, VEC[i][27]});
    end

    // six named skips at boundary accumulator values, both link values (R3, R4)
    for (int k = 0; k < 6; k++) begin
      for (int a = 0; a < 4; a++) begin
        for (int l = 0; l < 2; l++) begin
          logic e;
          case (k)
            0: e = acv[a][11];
            1: e = (acv[a] == 12'o0000);
            2: e = (l == 1);
            3: e = !acv[a][11];
            4: e = (acv[a] != 12'o0000);
            default: e = (l == 0);
          endcase
          apply(skop[k], acv[a], l[0], 12'o5252);
          check(k < 3 ? "R3" : "R4", $sformatf("op %o ac %o l %0d skip", skop[k], acv[a], l),
                {11'd0, skip}, {11'd0, e});
          check("R10", "named skip acc unchanged", acc_out, acv[a]);
        end
      end
    end

    // extension-class word with every other bit set stays neutral (R1, R2)
    apply(12'o7777, 12'o0000, 1'b1, 12'o7777);
    check("R1", "7777 grp_hit", {11'd0, grp_hit}, 12'd0);
    check("R2", "7777 acc_out", acc_out, 12'o0000);
    check("R2", "7777 halt", {11'd0, halt_req}, 12'd0);
    check("R2", "7777 skip", {11'd0, skip}, 12'd0);

    // halt drops once the word is removed (R9)
    apply(12'o7402, 12'o0000, 1'b0, 12'o0000);
    check("R9", "halt on", {11'd0, halt_req}, 12'd1);
    apply(12'o7400, 12'o0000, 1'b0, 12'o0000);
    check("R9", "halt off", {11'd0, halt_req}, 12'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule